// File: doc/BRIEF.md
# Programmable Logic Cell with Arithmetic Mode

This block is one programmable logic cell meant to be tiled across a reconfigurable fabric. It holds a 16-entry lookup table made of two 8-entry halves. Both halves are addressed by the same three data inputs.

In logic mode, the fourth data input chooses which half drives the result, so the cell computes any function of four inputs. In arithmetic mode, the two half outputs become the operands of a one-bit full adder, together with a carry input. The adder produces a sum and a carry output.

A configuration bit decides whether the cell output is the combinational result or the value held in a D flip-flop. The 18-bit configuration is loaded through a serial shift port. A serial output lets several cells share one configuration chain.

Top module: `logic_cell`

## Requirements
- R1: While `rst_n` is low, the configuration and the output flip-flop clear to zero, so `cell_out`, `carry_out` and `cfg_sout` read 0.
- R2: Each rising clock edge with `cfg_shift_en` high shifts `cfg_sin` into the configuration, most significant bit first. After 18 shifts the layout is: bit 17 selects registered output, bit 16 selects arithmetic mode, bits 15:8 hold the upper table half and bits 7:0 hold the lower half.
- R3: `cfg_sout` always presents configuration bit 17, so a chained cell receives the old contents in order while a new configuration shifts in.
- R4: Each table half is addressed by `{din[2],din[1],din[0]}`, with `din[0]` as the least significant address bit.
- R5: In logic mode, `din[3]=0` selects the lower-half entry and `din[3]=1` selects the upper-half entry, and `carry_out` is 0.
- R6: In arithmetic mode, the logic result is the XOR of the lower-half entry, the upper-half entry and `carry_in`.
- R7: In arithmetic mode, `carry_out` is the majority of the lower-half entry, the upper-half entry and `carry_in`.
- R8: With bit 17 clear, `cell_out` follows input changes with no clock edge.
- R9: With bit 17 set, `cell_out` shows the logic result captured at the previous rising edge on which shifting was idle.
- R10: The flip-flop keeps its value on every edge with `cfg_shift_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the cell |
| din | input | 4 | Data inputs; bits 2:0 address the table, bit 3 picks the half in logic mode |
| carry_in | input | 1 | Adder carry input |
| carry_out | output | 1 | Adder carry output, 0 in logic mode |
| cell_out | output | 1 | Cell result, combinational or registered |
| cfg_shift_en | input | 1 | Configuration shift enable |
| cfg_sin | input | 1 | Serial configuration input |
| cfg_sout | output | 1 | Serial configuration output for chaining |

## Verification
The bench builds the cell with its default of four data inputs, which gives an 18-bit configuration. At that size every data input value and carry value can be swept exhaustively for each loaded configuration. The sweep covers randomized tables in both modes and with both output settings.

Directed one-hot tables pin down the address bit order. Back-to-back loads expose the serial output ordering. Loads made while the output is registered show whether shifting disturbs the held flip-flop value.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic {
    LC_MODE_LOGIC = 1'b0,
    LC_MODE_ARITH = 1'b1
  } lc_mode_e;

  function automatic logic lc_majority(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/lc_rst_sync.sv
module lc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/lc_cfg_shift.sv
module lc_cfg_shift #(
  parameter int CFG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sin,
  output logic [CFG_W-1:0] cfg,
  output logic             sout
);
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg;
    if (shift_en) cfg_d = {cfg[CFG_W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else        cfg <= cfg_d;
  end

  assign sout = cfg[CFG_W-1];
endmodule

// File: rtl/lc_lut_half.sv
module lc_lut_half #(
  parameter int SEL_W = 3,
  localparam int ENTRIES = 1 << SEL_W
) (
  input  logic [ENTRIES-1:0] table_bits,
  input  logic [SEL_W-1:0]   sel,
  output logic               y
);
  logic [ENTRIES-1:0] stage [SEL_W+1];

  assign stage[0] = table_bits;

  for (genvar lvl = 0; lvl < SEL_W; lvl++) begin : g_lvl
    localparam int N = ENTRIES >> (lvl + 1);
    always_comb begin
      stage[lvl+1] = '0;
      for (int k = 0; k < N; k++) begin
        stage[lvl+1][k] = sel[lvl] ? stage[lvl][2*k+1] : stage[lvl][2*k];
      end
    end
  end

  assign y = stage[SEL_W][0];
endmodule

// File: rtl/lc_arith.sv
module lc_arith
  import lc_pkg::*;
(
  input  lc_mode_e mode,
  input  logic     lo,
  input  logic     hi,
  input  logic     half_sel,
  input  logic     cin,
  output logic     result,
  output logic     cout
);
  logic joined;
  logic sum;

  always_comb begin
    joined = half_sel ? hi : lo;
    sum    = lo ^ hi ^ cin;
    if (mode == LC_MODE_ARITH) begin
      result = sum;
      cout   = lc_majority(lo, hi, cin);
    end else begin
      result = joined;
      cout   = 1'b0;
    end
  end
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lc_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] din,
  input  logic              carry_in,
  output logic              carry_out,
  output logic              cell_out,
  input  logic              cfg_shift_en,
  input  logic              cfg_sin,
  output logic              cfg_sout
);
  localparam int SEL_W   = NUM_IN - 1;
  localparam int HALF    = 1 << SEL_W;
  localparam int TBL_W   = 2 * HALF;
  localparam int CFG_W   = TBL_W + 2;
  localparam int MODE_IX = CFG_W - 2;
  localparam int REG_IX  = CFG_W - 1;

  logic             rst_int_n;
  logic [CFG_W-1:0] cfg_q;
  logic             lut_lo;
  logic             lut_hi;
  logic             logic_res;
  logic             ff_en;
  logic             q_d;
  logic             q_r;
  lc_mode_e         mode;

  lc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_int_n)
  );

  lc_cfg_shift #(.CFG_W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .shift_en(cfg_shift_en),
    .sin     (cfg_sin),
    .cfg     (cfg_q),
    .sout    (cfg_sout)
  );

  lc_lut_half #(.SEL_W(SEL_W)) u_lo (
    .table_bits(cfg_q[HALF-1:0]),
    .sel       (din[SEL_W-1:0]),
    .y         (lut_lo)
  );

  lc_lut_half #(.SEL_W(SEL_W)) u_hi (
    .table_bits(cfg_q[TBL_W-1:HALF]),
    .sel       (din[SEL_W-1:0]),
    .y         (lut_hi)
  );

  assign mode = lc_mode_e'(cfg_q[MODE_IX]);

  lc_arith u_arith (
    .mode    (mode),
    .lo      (lut_lo),
    .hi      (lut_hi),
    .half_sel(din[NUM_IN-1]),
    .cin     (carry_in),
    .result  (logic_res),
    .cout    (carry_out)
  );

  assign ff_en = ~cfg_shift_en;

  always_comb begin
    q_d = q_r;
    if (ff_en) q_d = logic_res;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) q_r <= 1'b0;
    else            q_r <= q_d;
  end

  assign cell_out = cfg_q[REG_IX] ? q_r : logic_res;
endmodule

// File: rtl/lc_cell_chk.sv
module lc_cell_chk #(
  parameter int CFG_W = 18
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             shift_en,
  input logic             carry_in,
  input logic             carry_out,
  input logic             cell_out,
  input logic             cfg_sout,
  input logic [CFG_W-1:0] cfg,
  input logic             lo,
  input logic             hi,
  input logic             logic_res,
  input logic             q
);
  localparam int MODE_IX = CFG_W - 2;
  localparam int REG_IX  = CFG_W - 1;

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg[MODE_IX] |-> carry_out == 1'b0); // R5

  AST_ARITH_SUM: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg[MODE_IX] && !cfg[REG_IX]) |-> cell_out == (lo ^ hi ^ carry_in)); // R6

  AST_ARITH_CARRY: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg[MODE_IX] |-> carry_out == ((lo & hi) | (lo & carry_in) | (hi & carry_in))); // R7

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !shift_en |=> $stable(cfg)); // R2

  AST_SOUT_CHAIN: assert property (@(posedge clk) disable iff (!rst_int_n)
    shift_en |=> cfg_sout == $past(cfg[MODE_IX])); // R3

  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!shift_en && cfg[REG_IX]) |=> cell_out == $past(logic_res)); // R9

  AST_SHIFT_HOLDS_FF: assert property (@(posedge clk) disable iff (!rst_int_n)
    shift_en |=> $stable(q)); // R10
endmodule

bind logic_cell lc_cell_chk #(.CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst_int_n(rst_int_n),
  .shift_en (cfg_shift_en),
  .carry_in (carry_in),
  .carry_out(carry_out),
  .cell_out (cell_out),
  .cfg_sout (cfg_sout),
  .cfg      (cfg_q),
  .lo       (lut_lo),
  .hi       (lut_hi),
  .logic_res(logic_res),
  .q        (q_r)
);

// File: tb/logic_cell_tb.sv
`timescale 1ns/1ps
module logic_cell_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] din;
  logic       carry_in;
  logic       carry_out;
  logic       cell_out;
  logic       cfg_shift_en;
  logic       cfg_sin;
  logic       cfg_sout;

  int checks = 0;
  int failures = 0;
  logic [17:0] cur_cfg = '0;
  logic        model_live = 1'b0;
  logic        mq = 1'b0;

  always #5 clk = ~clk;

  logic_cell u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .carry_in(carry_in),
    .carry_out(carry_out), .cell_out(cell_out), .cfg_shift_en(cfg_shift_en),
    .cfg_sin(cfg_sin), .cfg_sout(cfg_sout)
  );

  function automatic logic ref_logic(input logic [17:0] c, input logic [3:0] x, input logic ci);
    int idx = int'(x[2:0]);
    logic lo = c[idx];
    logic hi = c[8 + idx];
    if (c[16]) return lo ^ hi ^ ci;
    return x[3] ? hi : lo;
  endfunction

  function automatic logic ref_cout(input logic [17:0] c, input logic [3:0] x, input logic ci);
    int idx = int'(x[2:0]);
    int total = int'(c[idx]) + int'(c[8 + idx]) + int'(ci);
    if (!c[16]) return 1'b0;
    return total >= 2;
  endfunction

  always @(posedge clk) begin
    if (model_live && !cfg_shift_en) mq <= ref_logic(cur_cfg, din, carry_in);
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b cfg=%h din=%h cin=%b", tag, act, exp, cur_cfg, din, carry_in);
    end
  endtask

  task automatic load_cfg(input logic [17:0] c);
    for (int i = 17; i >= 0; i--) begin
      @(negedge clk);
      check("R2 R3 sout", cfg_sout, cur_cfg[i]);
      cfg_shift_en = 1'b1;
      cfg_sin = c[i];
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
    cur_cfg = c;
    #1;
    if (c[17]) check("R10 held", cell_out, mq);
  endtask

  task automatic step(input logic [3:0] x, input logic ci);
    @(negedge clk);
    din = x;
    carry_in = ci;
    #1;
    check(cur_cfg[16] ? "R7 cout" : "R5 cout", carry_out, ref_cout(cur_cfg, x, ci));
    if (!cur_cfg[17])
      check(cur_cfg[16] ? "R6 R8 comb" : "R5 R8 comb", cell_out, ref_logic(cur_cfg, x, ci));
    @(posedge clk);
    #1;
    if (cur_cfg[17]) check("R9 reg", cell_out, mq);
  endtask

  initial begin
    rst_n = 1'b0;
    din = '0;
    carry_in = 1'b0;
    cfg_shift_en = 1'b0;
    cfg_sin = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 cell_out", cell_out, 1'b0);
    check("R1 carry_out", carry_out, 1'b0);
    check("R1 sout", cfg_sout, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_live = 1'b1;

    // R4: one-hot lower half, logic mode, d=0
    for (int k = 0; k < 8; k++) begin
      load_cfg({2'b00, 8'h00, 8'(1 << k)});
      for (int a = 0; a < 8; a++) begin
        @(negedge clk);
        din = 4'(a);
        carry_in = 1'b0;
        #1;
        check("R4 addr", cell_out, (a == k));
      end
    end

    // R5: upper half all ones, lower zeros; d picks the half
    load_cfg({2'b00, 8'hFF, 8'h00});
    for (int a = 0; a < 16; a++) step(4'(a), 1'b0);

    // Randomized tables, all mode/output combinations
    for (int n = 0; n < 10; n++) begin
      logic [15:0] tbl = 16'($urandom);
      for (int s = 0; s < 4; s++) begin
        load_cfg({2'(s), tbl});
        for (int v = 0; v < 32; v++) step(4'(v), v[4]);
      end
    end

    // R10: reload while registered, inputs unchanged
    load_cfg({2'b11, 16'hA5C3});
    step(4'h7, 1'b1);
    load_cfg({2'b10, 16'h0FF0});
    step(4'h3, 1'b0);

    model_live = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule